// File: doc/BRIEF.md
# Register-mapped SPI master

This block is a small serial-bus master sitting behind a 16-bit register port. Software programs a control word, then writes a data word. The write launches a transfer of one or two bytes on the serial lines. The byte that holds the higher bits goes out first, and each byte goes out most significant bit first. The bits clocked in from the slave replace the data register. A read of the data register returns those bits and wipes the status word.

Transfers run whether or not the module enable bit is set. The enable bit only gates the interrupt line. The status busy flag rises when a transfer is accepted and stays high until software reads the data register. As a result, every transfer has to be read out before a new one can start.

Top module: `spi_host_ctrl`

## Requirements
- R1: Offsets 0x0 (data), 0x2 (control) and 0x4 (status) are decoded. A read of any other offset returns 0x0000, and a write to any other offset changes no register.
- R2: After reset the data, control and status registers all read 0x0000, irq is low and sclk is low.
- R3: The control register stores all 16 written bits and reads them back unchanged. Its fields are: bit 0 enable, bit 2 wide (1 = two bytes, 0 = one byte), bit 5 receive interrupt enable, bit 6 done interrupt enable, bit 7 late sampling, bit 8 idle-high clock, bits 15:9 divider.
- R4: In wide mode a data write shifts out wdata[15:0] on mosi, MSB first. In narrow mode it shifts out only wdata[7:0], MSB first.
- R5: When a transfer ends, the data register holds the received bits in arrival order, with the first bit in the MSB. In narrow mode bits 15:8 are zero. The status register then reads 0x0003 (bit 0 busy, bit 1 receive full).
- R6: A read of the data register returns its contents, and the status register reads 0x0000 afterwards.
- R7: Writes to the status register are ignored.
- R8: irq is low whenever the enable bit is clear.
- R9: While enabled, irq is high when busy is clear and the done interrupt enable is set. It is also high when receive full is set and the receive interrupt enable is set. In all other cases it is low.
- R10: sclk rests at the idle-high bit while no transfer runs. Each sclk half period lasts divider+1 clock cycles.
- R11: With late sampling clear, miso is sampled on the first edge of each bit and mosi changes on the second edge. With late sampling set, mosi changes on the first edge and miso is sampled on the second.
- R12: A data write sets busy (status reads 0x0001 during the transfer). A data write while busy is set starts nothing and does not alter the outcome of the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while rd_en is high |
| irq | output | 1 | Interrupt request, level |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |

## Verification
The bench builds the block with ADDR_W = 12, DIV_W = 7 and MISO_SYNC = 0. With no input synchronizer, divider values down to zero are legal, so the table walks dividers 0 to 3 across both word widths, both idle levels and both sampling phases. A bench slave answers on the bus and records mosi. A divider of 4 is used to count the sclk half period exactly.

// File: rtl/spi_host_pkg.sv
`timescale 1ns/1ps
package spi_host_pkg;
   localparam int REG_W      = 16;
   localparam int OFF_DATA   = 0;
   localparam int OFF_CTRL   = 2;
   localparam int OFF_STAT   = 4;
   localparam int CTRL_DIV_W = 7;

   // control word, MSB first
   typedef struct packed {
      logic [CTRL_DIV_W-1:0] divider;     // 15:9
      logic                  idle_high;   // 8
      logic                  late_sample; // 7
      logic                  done_ie;     // 6
      logic                  rx_ie;       // 5
      logic [1:0]            spare_hi;    // 4:3
      logic                  wide;        // 2
      logic                  spare_lo;    // 1
      logic                  enable;      // 0
   } ctrl_t;
endpackage

// File: rtl/spi_host_clkdiv.sv
`timescale 1ns/1ps
module spi_host_clkdiv #(
   parameter int DIV_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] limit,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/spi_host_engine.sv
`timescale 1ns/1ps
module spi_host_engine #(
   parameter int WORD_W    = 16,
   parameter int DIV_W     = 7,
   parameter int MISO_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wide,
   input  logic              late_sample,
   input  logic              idle_high,
   input  logic [DIV_W-1:0]  divider,
   input  logic [WORD_W-1:0] tx_word,
   output logic              active,
   output logic              done,
   output logic [WORD_W-1:0] rx_word,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso
);
   localparam int HALF_W = WORD_W / 2;
   localparam int EDGE_W = $clog2(2 * WORD_W);
   localparam logic [EDGE_W-1:0] LAST_WIDE   = EDGE_W'(2 * WORD_W - 1);
   localparam logic [EDGE_W-1:0] LAST_NARROW = EDGE_W'(WORD_W - 1);

   generate
      if ((WORD_W % 2) != 0 || WORD_W < 4) begin : g_bad_word
         $error("spi_host_engine: WORD_W must be even and at least 4");
      end
      if (MISO_SYNC < 0) begin : g_bad_sync
         $error("spi_host_engine: MISO_SYNC must not be negative");
      end
   endgenerate

   logic              miso_s;
   logic              active_q, done_q, sclk_q, late_q, wide_q;
   logic [EDGE_W-1:0] edge_q;
   logic [DIV_W-1:0]  div_q;
   logic [WORD_W-1:0] tx_q, rx_q;
   logic              tick, is_sample, is_shift;
   logic [EDGE_W-1:0] last_edge;

   // optional miso resynchronizer; half period must exceed its depth
   generate
      if (MISO_SYNC == 0) begin : g_direct
         assign miso_s = miso;
      end else begin : g_sync
         logic [MISO_SYNC-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= MISO_SYNC'({sync_q, miso});
         end
         assign miso_s = sync_q[MISO_SYNC-1];
      end
   endgenerate

   spi_host_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (active_q),
      .limit (div_q),
      .tick  (tick)
   );

   assign last_edge = wide_q ? LAST_WIDE : LAST_NARROW;
   assign is_sample = late_q ? edge_q[0] : !edge_q[0];
   assign is_shift  = late_q ? (!edge_q[0] && (edge_q != '0)) : edge_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         done_q   <= 1'b0;
         sclk_q   <= 1'b0;
         late_q   <= 1'b0;
         wide_q   <= 1'b0;
         edge_q   <= '0;
         div_q    <= '0;
         tx_q     <= '0;
         rx_q     <= '0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            active_q <= 1'b1;
            edge_q   <= '0;
            sclk_q   <= idle_high;
            late_q   <= late_sample;
            wide_q   <= wide;
            div_q    <= divider;
            tx_q     <= wide ? tx_word : {tx_word[HALF_W-1:0], {HALF_W{1'b0}}};
            rx_q     <= '0;
         end else if (tick) begin
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + 1'b1;
            if (is_sample) rx_q <= {rx_q[WORD_W-2:0], miso_s};
            if (is_shift)  tx_q <= {tx_q[WORD_W-2:0], 1'b0};
            if (edge_q == last_edge) begin
               active_q <= 1'b0;
               done_q   <= 1'b1;
            end
         end
      end
   end

   assign active  = active_q;
   assign done    = done_q;
   assign rx_word = rx_q;
   assign sclk    = active_q ? sclk_q : idle_high;
   assign mosi    = tx_q[WORD_W-1];
endmodule

// File: rtl/spi_host_ctrl.sv
`timescale 1ns/1ps
module spi_host_ctrl
   import spi_host_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DIV_W     = 7,
   parameter int MISO_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   output logic              irq,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso
);
   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("spi_host_ctrl: ADDR_W must reach offset 4");
      end
      if (DIV_W < 1 || DIV_W > CTRL_DIV_W) begin : g_bad_div
         $error("spi_host_ctrl: DIV_W must fit the divider field");
      end
   endgenerate

   ctrl_t             ctrl_q;
   logic [REG_W-1:0]  data_q;
   logic              busy_q, full_q;
   logic              hit_data, hit_ctrl;
   logic              wr_data, rd_data, start;
   logic              eng_active, eng_done;
   logic [REG_W-1:0]  eng_rx;

   assign hit_data = (addr == ADDR_W'(OFF_DATA));
   assign hit_ctrl = (addr == ADDR_W'(OFF_CTRL));
   assign wr_data  = wr_en && hit_data;
   assign rd_data  = rd_en && hit_data;
   assign start    = wr_data && !busy_q && !eng_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (wr_en && hit_ctrl)
         ctrl_q <= ctrl_t'(wdata);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         full_q <= 1'b0;
         data_q <= '0;
      end else if (eng_done) begin
         busy_q <= 1'b1;
         full_q <= 1'b1;
         data_q <= eng_rx;
      end else if (start) begin
         busy_q <= 1'b1;
         full_q <= 1'b0;
      end else if (rd_data) begin
         busy_q <= 1'b0;
         full_q <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (addr)
            ADDR_W'(OFF_DATA): rdata = data_q;
            ADDR_W'(OFF_CTRL): rdata = ctrl_q;
            ADDR_W'(OFF_STAT): rdata = {{(REG_W-2){1'b0}}, full_q, busy_q};
            default:           rdata = '0;
         endcase
      end
   end

   assign irq = ctrl_q.enable &&
                ((!busy_q && ctrl_q.done_ie) || (full_q && ctrl_q.rx_ie));

   spi_host_engine #(
      .WORD_W    (REG_W),
      .DIV_W     (DIV_W),
      .MISO_SYNC (MISO_SYNC)
   ) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .wide        (ctrl_q.wide),
      .late_sample (ctrl_q.late_sample),
      .idle_high   (ctrl_q.idle_high),
      .divider     (ctrl_q.divider[DIV_W-1:0]),
      .tx_word     (wdata),
      .active      (eng_active),
      .done        (eng_done),
      .rx_word     (eng_rx),
      .sclk        (sclk),
      .mosi        (mosi),
      .miso        (miso)
   );
endmodule

// File: rtl/spi_host_chk.sv
`timescale 1ns/1ps
module spi_host_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        enable,
   input logic        rx_ie,
   input logic        done_ie,
   input logic        idle_high,
   input logic        busy,
   input logic        full,
   input logic        irq,
   input logic        rd_hit,
   input logic        wr_hit,
   input logic        eng_done,
   input logic        eng_active,
   input logic [15:0] data_q,
   input logic        sclk
);
   p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !irq);

   p_irq_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && rx_ie && full) |-> irq);

   p_irq_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && done_ie && !busy) |-> irq);

   p_end_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> (busy && full));

   p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && !eng_done && !wr_hit) |=> (!busy && !full));

   p_start_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !busy && !eng_active) |=> (busy && eng_active));

   p_busy_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && busy && !eng_done) |=> $stable(data_q));

   p_sclk_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_active |-> (sclk == idle_high));
endmodule

bind spi_host_ctrl spi_host_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (ctrl_q.enable),
   .rx_ie      (ctrl_q.rx_ie),
   .done_ie    (ctrl_q.done_ie),
   .idle_high  (ctrl_q.idle_high),
   .busy       (busy_q),
   .full       (full_q),
   .irq        (irq),
   .rd_hit     (rd_data),
   .wr_hit     (wr_data),
   .eng_done   (eng_done),
   .eng_active (eng_active),
   .data_q     (data_q),
   .sclk       (sclk)
);

// File: tb/spi_host_ctrl_bench.sv
`timescale 1ns/1ps
module spi_host_ctrl_bench;
   localparam int ADDR_W = 12;
   localparam logic [ADDR_W-1:0] A_DATA = 12'h000;
   localparam logic [ADDR_W-1:0] A_CTRL = 12'h002;
   localparam logic [ADDR_W-1:0] A_STAT = 12'h004;

   // {control, write data, slave reply}
   localparam logic [47:0] VEC [4] = '{
      48'h0021_12A5_003C,
      48'h0285_BEEF_C3A1,
      48'h0704_8001_7FFE,
      48'h05C1_00FF_0081
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic              rd_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [15:0]       wdata = '0;
   logic [15:0]       rdata;
   logic              irq, sclk, mosi;
   logic              miso = 1'b0;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   // bench slave
   logic        tb_cpol = 1'b0, tb_cpha = 1'b0, xfer_on = 1'b0;
   logic [15:0] slv_word = '0, cap = '0;
   int          slv_n = 8, slv_k = 0;

   always #2.5 clk = ~clk;

   spi_host_ctrl #(.ADDR_W(ADDR_W)) u_spi_host_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq), .sclk(sclk), .mosi(mosi),
      .miso(miso)
   );

   always @(sclk) begin
      if (xfer_on) begin
         if ((sclk != tb_cpol) != tb_cpha) begin
            cap = {cap[14:0], mosi};
         end else if (tb_cpha) begin
            if (slv_k < slv_n) miso = slv_word[slv_n-1-slv_k];
            slv_k++;
         end else begin
            slv_k++;
            if (slv_k < slv_n) miso = slv_word[slv_n-1-slv_k];
         end
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [15:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic arm(input logic [15:0] ctrl, input logic [15:0] reply);
      tb_cpol  = ctrl[8];
      tb_cpha  = ctrl[7];
      slv_word = reply;
      slv_n    = ctrl[2] ? 16 : 8;
      slv_k    = 0;
      cap      = '0;
      miso     = ctrl[7] ? 1'b0 : reply[slv_n-1];
      xfer_on  = 1'b1;
   endtask

   task automatic wait_full();
      logic [15:0] s;
      for (int i = 0; i < 2000; i++) begin
         rd(A_STAT, s);
         if (s[1]) break;
      end
      xfer_on = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [15:0] r, ctrl, wd, sw, exp_rx, exp_tx;
      int cnt, changes;
      logic last;

      repeat (3) @(negedge clk);
      // R2 reset state
      chk("R2 irq", {15'h0, irq}, 16'h0);
      chk("R2 sclk", {15'h0, sclk}, 16'h0);
      rst_n = 1'b1;
      rd(A_DATA, r); chk("R2 data", r, 16'h0000);
      rd(A_CTRL, r); chk("R2 ctrl", r, 16'h0000);
      rd(A_STAT, r); chk("R2 stat", r, 16'h0000);

      // vector table: R4 R5 R6 R9 R11 R12
      foreach (VEC[v]) begin
         ctrl = VEC[v][47:32];
         wd   = VEC[v][31:16];
         sw   = VEC[v][15:0];
         wr(A_CTRL, ctrl);
         arm(ctrl, sw);
         wr(A_DATA, wd);
         rd(A_STAT, r); chk("R12 busy during transfer", r, 16'h0001);
         wait_full();
         rd(A_STAT, r); chk("R5 status at end", r, 16'h0003);
         exp_rx = ctrl[2] ? sw : {8'h00, sw[7:0]};
         exp_tx = ctrl[2] ? wd : {8'h00, wd[7:0]};
         chk("R4 R11 mosi bits", cap, exp_tx);
         chk("R9 irq when full", {15'h0, irq}, {15'h0, ctrl[0] & ctrl[5]});
         rd(A_DATA, r); chk("R5 R11 received word", r, exp_rx);
         rd(A_STAT, r); chk("R6 status cleared", r, 16'h0000);
         chk("R9 irq when idle", {15'h0, irq}, {15'h0, ctrl[0] & ctrl[6]});
      end

      // R3 control readback
      wr(A_CTRL, 16'hA5A5);
      rd(A_CTRL, r); chk("R3 ctrl readback", r, 16'hA5A5);

      // R1 undecoded offsets
      wr(12'h006, 16'h1234);
      rd(12'h006, r); chk("R1 unmapped read", r, 16'h0000);
      wr(12'h008, 16'hFFFF);
      rd(A_CTRL, r); chk("R1 ctrl untouched", r, 16'hA5A5);
      rd(A_DATA, r); chk("R1 data untouched", r, 16'h0081);

      // R7 status is read-only
      wr(A_STAT, 16'hFFFF);
      rd(A_STAT, r); chk("R7 status write ignored", r, 16'h0000);

      // R8 / R9 interrupt gating with idle status
      wr(A_CTRL, 16'h0040);
      chk("R8 irq off when disabled", {15'h0, irq}, 16'h0);
      wr(A_CTRL, 16'h0041);
      chk("R9 irq on not busy", {15'h0, irq}, 16'h1);
      wr(A_CTRL, 16'h0021);
      chk("R9 irq off without full", {15'h0, irq}, 16'h0);

      // R10 idle level
      wr(A_CTRL, 16'h0100);
      #1 chk("R10 idle high", {15'h0, sclk}, 16'h1);
      wr(A_CTRL, 16'h0000);
      #1 chk("R10 idle low", {15'h0, sclk}, 16'h0);

      // R10 half period with divider 4
      wr(A_CTRL, 16'h0800);
      arm(16'h0800, 16'h005A);
      wr(A_DATA, 16'h0066);
      cnt = 0;
      for (int i = 0; i < 100 && sclk == 1'b0; i++) @(negedge clk);
      for (int i = 0; i < 100 && sclk == 1'b1; i++) begin
         cnt++;
         @(negedge clk);
      end
      chk("R10 half period", 16'(cnt), 16'd5);
      wait_full();
      rd(A_DATA, r); chk("R10 data at divider 4", r, 16'h005A);

      // R12 writes while busy are ignored
      wr(A_CTRL, 16'h0600);
      arm(16'h0600, 16'h0055);
      wr(A_DATA, 16'h00AA);
      wr(A_DATA, 16'h0033);
      wait_full();
      chk("R12 mosi from first write", cap, 16'h00AA);
      wr(A_DATA, 16'h00C3);
      changes = 0;
      last = sclk;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (sclk != last) changes++;
         last = sclk;
      end
      chk("R12 no start while busy", 16'(changes), 16'd0);
      rd(A_STAT, r); chk("R12 status held", r, 16'h0003);
      rd(A_DATA, r); chk("R12 data from first transfer", r, 16'h0055);
      rd(A_STAT, r); chk("R6 status cleared again", r, 16'h0000);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule